// File: doc/BRIEF.md
# Working Register File with 16-bit Pointer Pairs

This block holds the thirty-two 8-bit working registers of a small 8-bit processing core. Two read ports are combinational and one write port commits on the clock edge, so an arithmetic unit can fetch both operands and store its result in one cycle. Operations that carry an immediate operand may only target the upper half of the file. When such an operation names a lower register, the block raises a flag and drops the write.

The six highest registers pair up into three 16-bit address pointers, each stored low byte first. A pointer port reads the selected pointer as one word. It can add a small unsigned displacement to it, or write it back incremented after use or decremented before use. Both bytes change in the same cycle.

A memory-style access port lets data addresses 0x00 to 0x1F reach the registers directly. Addresses at or above 0x20 are left to other blocks.

Top module: `wreg_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 32 registers to zero.
- R2: `rd_a_data` and `rd_b_data` show the registers named by `rd_a_sel` and `rd_b_sel` combinationally. The value shown is the one held before the edge. A write to the same register in the same cycle becomes visible only after that edge, with no bypass.
- R3: When `wr_en` is high and the write is legal, `wr_data` is stored into register `wr_sel` at the rising edge.
- R4: When `wr_en` and `wr_imm` are both high and `wr_sel` is below 16, `imm_illegal` is 1 and no register changes through the write port. For `wr_sel` from 16 to 31 the immediate-form write proceeds and `imm_illegal` is 0.
- R5: `ptr_sel` picks a pointer. Value 0 selects registers 26 (low byte) and 27 (high byte), value 1 selects 28/29, and value 2 selects 30/31. Value 3 selects nothing: `ptr_addr` is 0 and no register is updated.
- R6: With `ptr_op` = 0, `ptr_addr` equals the selected pointer. With `ptr_op` = 1, `ptr_addr` equals the pointer plus the zero-extended `ptr_disp`, modulo 2^16. In both cases the pointer is unchanged.
- R7: With `ptr_op` = 2 (post-increment), `ptr_addr` is the old pointer value. Both bytes take the old value plus 1, modulo 2^16, at the edge.
- R8: With `ptr_op` = 3 (pre-decrement), `ptr_addr` is the old value minus 1, modulo 2^16. Both bytes take that value at the edge.
- R9: If a pointer update (`ptr_op` 2 or 3) and a legal write-port write hit the same register in one cycle, the write-port data is stored there. The pointer's other byte still takes its updated value, and `ptr_conflict` is 1 during that cycle.
- R10: When `mem_en` is high and `mem_addr` is below 0x20, `mem_hit` is 1 and `mem_rdata` shows register `mem_addr` combinationally. If `mem_we` is also high, `mem_wdata` is stored into that register at the edge.
- R11: When `mem_addr` is 0x20 or above, including addresses whose low five bits point at a register, `mem_hit` is 0, `mem_rdata` is 0, and a write changes nothing.
- R12: When several sources write the same register in one cycle, the write port wins over the memory port, and the memory port wins over a pointer update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_sel | input | 5 | Register index, read port A |
| rd_a_data | output | 8 | Read data, port A |
| rd_b_sel | input | 5 | Register index, read port B |
| rd_b_data | output | 8 | Read data, port B |
| wr_en | input | 1 | Write-port enable |
| wr_imm | input | 1 | Write comes from an immediate-form operation |
| wr_sel | input | 5 | Write-port register index |
| wr_data | input | 8 | Write-port data |
| imm_illegal | output | 1 | Immediate-form write names a register below 16 |
| ptr_op | input | 2 | 0 read, 1 displaced, 2 post-increment, 3 pre-decrement |
| ptr_sel | input | 2 | Pointer select (0, 1, 2; 3 selects none) |
| ptr_disp | input | 6 | Unsigned displacement for `ptr_op` 1 |
| ptr_addr | output | 16 | Effective pointer address |
| ptr_conflict | output | 1 | Pointer update overlapped by a write-port write |
| mem_en | input | 1 | Memory-style access valid |
| mem_we | input | 1 | Memory-style write |
| mem_addr | input | 16 | Data-space address |
| mem_wdata | input | 8 | Memory-style write data |
| mem_rdata | output | 8 | Memory-style read data |
| mem_hit | output | 1 | Address falls inside the register window |

## Verification
The bench builds the block with its default parameters: 32 registers of 8 bits, three pointers in the top six registers, a 6-bit displacement and a 16-bit data address. These values bring the 0xFFFF/0x0000 wrap of increment, decrement and displacement within reach, along with the byte carry from 0x00FF to 0x0100 and the window edge between 0x1F and 0x20. They also make reachable an aliasing address such as 0x1020, whose low bits name a register. Collisions among the three write sources are driven onto pointer bytes, so that the priority order and the conflict flag can be seen on the read ports one cycle later.

// File: rtl/wreg_file_pkg.sv
package wreg_file_pkg;

  // Pointer operation encoding (R6, R7, R8)
  typedef enum logic [1:0] {
    PTR_READ    = 2'd0,
    PTR_DISP    = 2'd1,
    PTR_POSTINC = 2'd2,
    PTR_PREDEC  = 2'd3
  } ptr_op_e;

  // True when the operation rewrites the pointer
  function automatic logic ptr_op_updates(input ptr_op_e op);
    return (op == PTR_POSTINC) || (op == PTR_PREDEC);
  endfunction

endpackage

// File: rtl/wreg_ptr_unit.sv
module wreg_ptr_unit
  import wreg_file_pkg::*;
#(
  parameter int NREGS    = 32,
  parameter int DW       = 8,
  parameter int NPTR     = 3,
  parameter int DISP_W   = 6,
  parameter int SEL_W    = $clog2(NREGS),
  parameter int PSEL_W   = 2,
  parameter int PTR_BASE = NREGS - 2 * NPTR,
  parameter int PW       = 2 * DW
) (
  input  logic [NREGS-1:0][DW-1:0] regs,
  input  ptr_op_e                  op,
  input  logic [PSEL_W-1:0]        sel,
  input  logic [DISP_W-1:0]        disp,
  output logic [PW-1:0]            addr,
  output logic [NREGS-1:0]         we_vec,
  output logic [NREGS-1:0][DW-1:0] wval_vec
);

  // Pointer arithmetic, all modulo 2^PW
  function automatic logic [PW-1:0] ptr_plus_one(input logic [PW-1:0] v);
    return v + PW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_minus_one(input logic [PW-1:0] v);
    return v - PW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_offset(input logic [PW-1:0] v,
                                               input logic [DISP_W-1:0] d);
    return v + PW'(d);
  endfunction

  logic             sel_valid;
  logic [PW-1:0]    cur;
  logic [PW-1:0]    nxt;
  logic [SEL_W-1:0] lo_idx;
  logic [SEL_W-1:0] hi_idx;

  // Select one pointer first, so a single adder serves all three (R5)
  always_comb begin
    sel_valid = 1'b0;
    cur       = '0;
    lo_idx    = '0;
    hi_idx    = '0;
    for (int p = 0; p < NPTR; p++) begin
      if (sel == PSEL_W'(p)) begin
        sel_valid = 1'b1;
        cur       = {regs[PTR_BASE + 2 * p + 1], regs[PTR_BASE + 2 * p]};
        lo_idx    = SEL_W'(PTR_BASE + 2 * p);
        hi_idx    = SEL_W'(PTR_BASE + 2 * p + 1);
      end
    end
  end

  // Effective address and written-back value (R6, R7, R8)
  always_comb begin
    nxt  = cur;
    addr = '0;
    if (sel_valid) begin
      unique case (op)
        PTR_READ:    addr = cur;
        PTR_DISP:    addr = ptr_offset(cur, disp);
        PTR_POSTINC: begin
          nxt  = ptr_plus_one(cur);
          addr = cur;
        end
        PTR_PREDEC:  begin
          nxt  = ptr_minus_one(cur);
          addr = nxt;
        end
        default:     addr = cur;
      endcase
    end
  end

  // Both bytes are written together, low byte in the even register
  always_comb begin
    we_vec   = '0;
    wval_vec = '0;
    if (sel_valid && ptr_op_updates(op)) begin
      we_vec[lo_idx]   = 1'b1;
      we_vec[hi_idx]   = 1'b1;
      wval_vec[lo_idx] = nxt[DW-1:0];
      wval_vec[hi_idx] = nxt[PW-1:DW];
    end
  end

endmodule

// File: rtl/wreg_mem_port.sv
module wreg_mem_port #(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  parameter int AW    = 16,
  parameter int SEL_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][DW-1:0] regs,
  input  logic                     en,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  output logic                     hit,
  output logic [DW-1:0]            rdata,
  output logic [NREGS-1:0]         we_vec
);

  // Window check: full address compare, so aliases above it miss (R11)
  function automatic logic in_window(input logic [AW-1:0] a);
    return a < AW'(NREGS);
  endfunction

  logic [SEL_W-1:0] idx;

  assign idx   = addr[SEL_W-1:0];
  assign hit   = en && in_window(addr);
  assign rdata = hit ? regs[idx] : '0;

  // One-hot write enable across the register window (R10)
  for (genvar i = 0; i < NREGS; i++) begin : g_dec
    assign we_vec[i] = hit && we && (idx == SEL_W'(i));
  end

endmodule

// File: rtl/wreg_write_arb.sv
module wreg_write_arb #(
  parameter int NREGS = 32,
  parameter int DW    = 8
) (
  input  logic [NREGS-1:0]         alu_we,
  input  logic [DW-1:0]            alu_data,
  input  logic [NREGS-1:0]         mem_we,
  input  logic [DW-1:0]            mem_data,
  input  logic [NREGS-1:0]         ptr_we,
  input  logic [NREGS-1:0][DW-1:0] ptr_val,
  output logic [NREGS-1:0]         nxt_we,
  output logic [NREGS-1:0][DW-1:0] nxt_val,
  output logic [NREGS-1:0]         clash_vec
);

  // Per-register fixed priority: write port, then memory port, then pointer (R12)
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    assign nxt_we[i]    = alu_we[i] | mem_we[i] | ptr_we[i];
    assign nxt_val[i]   = alu_we[i] ? alu_data :
                          mem_we[i] ? mem_data : ptr_val[i];
    // Only the write-port against pointer overlap is reported (R9)
    assign clash_vec[i] = alu_we[i] & ptr_we[i];
  end

endmodule

// File: rtl/wreg_file.sv
module wreg_file
  import wreg_file_pkg::*;
#(
  parameter int NREGS    = 32,
  parameter int DW       = 8,
  parameter int NPTR     = 3,
  parameter int IMM_BASE = 16,
  parameter int DISP_W   = 6,
  parameter int AW       = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(NREGS)-1:0]   rd_a_sel,
  output logic [DW-1:0]              rd_a_data,
  input  logic [$clog2(NREGS)-1:0]   rd_b_sel,
  output logic [DW-1:0]              rd_b_data,
  input  logic                       wr_en,
  input  logic                       wr_imm,
  input  logic [$clog2(NREGS)-1:0]   wr_sel,
  input  logic [DW-1:0]              wr_data,
  output logic                       imm_illegal,
  input  logic [1:0]                 ptr_op,
  input  logic [$clog2(NPTR+1)-1:0]  ptr_sel,
  input  logic [DISP_W-1:0]          ptr_disp,
  output logic [2*DW-1:0]            ptr_addr,
  output logic                       ptr_conflict,
  input  logic                       mem_en,
  input  logic                       mem_we,
  input  logic [AW-1:0]              mem_addr,
  input  logic [DW-1:0]              mem_wdata,
  output logic [DW-1:0]              mem_rdata,
  output logic                       mem_hit
);

  localparam int SEL_W    = $clog2(NREGS);
  localparam int PSEL_W   = $clog2(NPTR + 1);
  localparam int PTR_BASE = NREGS - 2 * NPTR;
  localparam int PW       = 2 * DW;

  // Storage and named internal events
  logic [NREGS-1:0][DW-1:0] rf_q;
  logic [NREGS-1:0]         alu_we_vec;
  logic [NREGS-1:0]         mem_we_vec;
  logic [NREGS-1:0]         ptr_we_vec;
  logic [NREGS-1:0][DW-1:0] ptr_wval_vec;
  logic [NREGS-1:0]         nxt_we;
  logic [NREGS-1:0][DW-1:0] nxt_val;
  logic [NREGS-1:0]         clash_vec;
  logic                     alu_write_ok;

  // Read ports show the pre-edge contents, no bypass (R2)
  assign rd_a_data = rf_q[rd_a_sel];
  assign rd_b_data = rf_q[rd_b_sel];

  // Immediate-form target check (R4)
  assign imm_illegal  = wr_en && wr_imm && (wr_sel < SEL_W'(IMM_BASE));
  assign alu_write_ok = wr_en && !imm_illegal;

  for (genvar i = 0; i < NREGS; i++) begin : g_alu_dec
    assign alu_we_vec[i] = alu_write_ok && (wr_sel == SEL_W'(i));
  end

  wreg_ptr_unit #(
    .NREGS    (NREGS),
    .DW       (DW),
    .NPTR     (NPTR),
    .DISP_W   (DISP_W),
    .SEL_W    (SEL_W),
    .PSEL_W   (PSEL_W),
    .PTR_BASE (PTR_BASE),
    .PW       (PW)
  ) u_ptr (
    .regs     (rf_q),
    .op       (ptr_op_e'(ptr_op)),
    .sel      (ptr_sel),
    .disp     (ptr_disp),
    .addr     (ptr_addr),
    .we_vec   (ptr_we_vec),
    .wval_vec (ptr_wval_vec)
  );

  wreg_mem_port #(
    .NREGS (NREGS),
    .DW    (DW),
    .AW    (AW),
    .SEL_W (SEL_W)
  ) u_mem (
    .regs   (rf_q),
    .en     (mem_en),
    .we     (mem_we),
    .addr   (mem_addr),
    .hit    (mem_hit),
    .rdata  (mem_rdata),
    .we_vec (mem_we_vec)
  );

  wreg_write_arb #(
    .NREGS (NREGS),
    .DW    (DW)
  ) u_arb (
    .alu_we    (alu_we_vec),
    .alu_data  (wr_data),
    .mem_we    (mem_we_vec),
    .mem_data  (mem_wdata),
    .ptr_we    (ptr_we_vec),
    .ptr_val   (ptr_wval_vec),
    .nxt_we    (nxt_we),
    .nxt_val   (nxt_val),
    .clash_vec (clash_vec)
  );

  assign ptr_conflict = |clash_vec;

  // Register storage, synchronous clear (R1, R3)
  always_ff @(posedge clk) begin
    if (rst) begin
      rf_q <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (nxt_we[i]) rf_q[i] <= nxt_val[i];
      end
    end
  end

endmodule

// File: rtl/wreg_file_chk.sv
module wreg_file_chk #(
  parameter int NREGS    = 32,
  parameter int DW       = 8,
  parameter int NPTR     = 3,
  parameter int IMM_BASE = 16,
  parameter int AW       = 16
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            wr_en,
  input logic [$clog2(NREGS)-1:0]        wr_sel,
  input logic [DW-1:0]                   wr_data,
  input logic                            imm_illegal,
  input logic [1:0]                      ptr_op,
  input logic [$clog2(NPTR+1)-1:0]       ptr_sel,
  input logic                            ptr_conflict,
  input logic                            mem_en,
  input logic                            mem_we,
  input logic [AW-1:0]                   mem_addr,
  input logic [DW-1:0]                   mem_rdata,
  input logic                            mem_hit,
  input logic [NREGS-1:0][DW-1:0]        rf_q,
  input logic [NREGS-1:0]                ptr_we_vec
);

  localparam int SEL_W    = $clog2(NREGS);
  localparam int PSEL_W   = $clog2(NPTR + 1);
  localparam int PTR_BASE = NREGS - 2 * NPTR;
  localparam int PW       = 2 * DW;

  logic [PW-1:0] ptr_v [NPTR];
  logic          mem_write;

  for (genvar p = 0; p < NPTR; p++) begin : g_pv
    assign ptr_v[p] = {rf_q[PTR_BASE + 2 * p + 1], rf_q[PTR_BASE + 2 * p]};
  end

  assign mem_write = mem_en && mem_we;

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (rf_q == '0));

  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !imm_illegal) |=> (rf_q[$past(wr_sel)] == $past(wr_data)));

  a_r4_illegal_suppressed: assert property (@(posedge clk) disable iff (rst)
    (imm_illegal && !mem_write && !(|ptr_we_vec)) |=> (rf_q == $past(rf_q)));

  a_r4_flag_low_half: assert property (@(posedge clk) disable iff (rst)
    imm_illegal |-> (wr_en && (wr_sel < SEL_W'(IMM_BASE))));

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr_chk
    a_r7_postinc: assert property (@(posedge clk) disable iff (rst)
      (ptr_op == 2'd2 && ptr_sel == PSEL_W'(p) && !wr_en && !mem_write)
      |=> (ptr_v[p] == PW'($past(ptr_v[p]) + PW'(1))));

    a_r8_predec: assert property (@(posedge clk) disable iff (rst)
      (ptr_op == 2'd3 && ptr_sel == PSEL_W'(p) && !wr_en && !mem_write)
      |=> (ptr_v[p] == PW'($past(ptr_v[p]) - PW'(1))));
  end

  a_r9_conflict_cause: assert property (@(posedge clk) disable iff (rst)
    ptr_conflict |-> (wr_en && !imm_illegal && ptr_op[1]));

  a_r9_alu_wins: assert property (@(posedge clk) disable iff (rst)
    ptr_conflict |=> (rf_q[$past(wr_sel)] == $past(wr_data)));

  a_r10_mem_read: assert property (@(posedge clk) disable iff (rst)
    mem_hit |-> (mem_rdata == rf_q[mem_addr[SEL_W-1:0]]));

  a_r11_miss_quiet: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_addr >= AW'(NREGS)) |-> (!mem_hit && mem_rdata == '0));

endmodule

bind wreg_file wreg_file_chk #(
  .NREGS    (NREGS),
  .DW       (DW),
  .NPTR     (NPTR),
  .IMM_BASE (IMM_BASE),
  .AW       (AW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .imm_illegal  (imm_illegal),
  .ptr_op       (ptr_op),
  .ptr_sel      (ptr_sel),
  .ptr_conflict (ptr_conflict),
  .mem_en       (mem_en),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_rdata    (mem_rdata),
  .mem_hit      (mem_hit),
  .rf_q         (rf_q),
  .ptr_we_vec   (ptr_we_vec)
);

// File: tb/wreg_file_tb.sv
`timescale 1ns/1ps
module wreg_file_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_sel, rd_b_sel, wr_sel;
  logic [7:0]  rd_a_data, rd_b_data, wr_data, mem_wdata, mem_rdata;
  logic        wr_en, wr_imm, imm_illegal, ptr_conflict, mem_en, mem_we, mem_hit;
  logic [1:0]  ptr_op, ptr_sel;
  logic [5:0]  ptr_disp;
  logic [15:0] ptr_addr, mem_addr;

  always #10 clk = ~clk;

  wreg_file u_dut (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_imm(wr_imm), .wr_sel(wr_sel), .wr_data(wr_data),
    .imm_illegal(imm_illegal),
    .ptr_op(ptr_op), .ptr_sel(ptr_sel), .ptr_disp(ptr_disp),
    .ptr_addr(ptr_addr), .ptr_conflict(ptr_conflict),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_hit(mem_hit)
  );

  typedef struct {
    string       req;
    logic [7:0]  ra, rb, md;
    logic        ill, cf, hit;
    logic [15:0] pa;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] mdl [32];
  int         n_checks = 0;
  int         n_fail   = 0;
  bit         done     = 1'b0;

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expectation per cycle, samples well before the edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, "rd_a_data",    16'(rd_a_data),    16'(e.ra));
        chk(e.req, "rd_b_data",    16'(rd_b_data),    16'(e.rb));
        chk(e.req, "imm_illegal",  16'(imm_illegal),  16'(e.ill));
        chk(e.req, "ptr_addr",     ptr_addr,          e.pa);
        chk(e.req, "ptr_conflict", 16'(ptr_conflict), 16'(e.cf));
        chk(e.req, "mem_hit",      16'(mem_hit),      16'(e.hit));
        chk(e.req, "mem_rdata",    16'(mem_rdata),    16'(e.md));
      end
    end
  end

  task automatic idle();
    rd_a_sel = '0; rd_b_sel = '0;
    wr_en = 0; wr_imm = 0; wr_sel = '0; wr_data = '0;
    ptr_op = 2'd0; ptr_sel = 2'd3; ptr_disp = '0;
    mem_en = 0; mem_we = 0; mem_addr = '0; mem_wdata = '0;
  endtask

  // Driver: predicts from the requirements, pushes, then advances the model
  task automatic step(string req);
    exp_t        e;
    int          b;
    logic [15:0] cur, nv;
    logic        legal, upd;
    b     = 26 + 2 * int'(ptr_sel);
    cur   = (ptr_sel < 3) ? {mdl[b+1], mdl[b]} : 16'h0000;
    e.req = req;
    e.ra  = mdl[rd_a_sel];
    e.rb  = mdl[rd_b_sel];
    e.ill = wr_en && wr_imm && (wr_sel < 16);
    legal = wr_en && !e.ill;
    upd   = (ptr_sel < 3) && (ptr_op >= 2);
    nv    = (ptr_op == 2) ? cur + 16'd1 : cur - 16'd1;
    case (ptr_op)
      2'd0:    e.pa = cur;
      2'd1:    e.pa = cur + {10'd0, ptr_disp};
      2'd2:    e.pa = cur;
      default: e.pa = cur - 16'd1;
    endcase
    if (ptr_sel == 3) e.pa = 16'h0000;
    e.cf  = upd && legal && (wr_sel == 5'(b) || wr_sel == 5'(b + 1));
    e.hit = mem_en && (mem_addr < 16'd32);
    e.md  = e.hit ? mdl[mem_addr[4:0]] : 8'h00;
    sb_q.push_back(e);
    @(posedge clk);
    #1;
    if (upd) begin
      mdl[b]   = nv[7:0];
      mdl[b+1] = nv[15:8];
    end
    if (e.hit && mem_we) mdl[mem_addr[4:0]] = mem_wdata;
    if (legal) mdl[wr_sel] = wr_data;
    idle();
  endtask

  task automatic wr(int r, logic [7:0] d);
    wr_en = 1; wr_sel = 5'(r); wr_data = d;
    step("R3 write");
  endtask

  task automatic peek(int a, int bb, string req);
    rd_a_sel = 5'(a); rd_b_sel = 5'(bb);
    step(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    idle();
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1: every register is zero after reset
    for (int i = 0; i < 16; i++) peek(i, i + 16, "R1 reset clear");

    // R3 writes, R2 same-cycle read shows old value
    wr(0, 8'h11); wr(31, 8'h3C);
    rd_a_sel = 5; rd_b_sel = 5; wr_en = 1; wr_sel = 5; wr_data = 8'hA5;
    step("R2 no bypass");
    peek(5, 31, "R2 value after edge");
    peek(0, 5, "R3 readback");

    // R4 immediate-form legality
    wr_en = 1; wr_imm = 1; wr_sel = 15; wr_data = 8'hEE; rd_a_sel = 15;
    step("R4 illegal imm");
    peek(15, 16, "R4 suppressed");
    wr_en = 1; wr_imm = 1; wr_sel = 16; wr_data = 8'h77;
    step("R4 legal imm");
    peek(16, 15, "R4 upper half");

    // R5, R6 pointer read and displacement
    wr(26, 8'h34); wr(27, 8'h12);
    ptr_sel = 0; ptr_op = 0; step("R5 X as word");
    ptr_sel = 0; ptr_op = 1; ptr_disp = 6'h3F; step("R6 displaced");
    wr(30, 8'hF0); wr(31, 8'hFF);
    ptr_sel = 2; ptr_op = 1; ptr_disp = 6'h3F; step("R6 displaced wrap");
    peek(30, 31, "R6 pointer unchanged");
    ptr_sel = 3; ptr_op = 2; step("R5 no pointer");
    peek(30, 26, "R5 nothing updated");

    // R7 post-increment with carry and wrap
    wr(28, 8'hFF); wr(29, 8'h00);
    ptr_sel = 1; ptr_op = 2; step("R7 postinc carry");
    peek(28, 29, "R7 both bytes");
    wr(30, 8'hFF);
    ptr_sel = 2; ptr_op = 2; step("R7 postinc wrap");
    peek(30, 31, "R7 wrapped");

    // R8 pre-decrement
    ptr_sel = 0; ptr_op = 3; step("R8 predec");
    ptr_sel = 1; ptr_op = 3; step("R8 predec borrow");
    ptr_sel = 2; ptr_op = 3; step("R8 predec wrap");
    peek(30, 31, "R8 wrapped");
    ptr_sel = 1; ptr_op = 0; step("R8 readback");

    // R9 conflict: write port hits the high byte of a post-incremented pointer
    ptr_sel = 0; ptr_op = 2; wr_en = 1; wr_sel = 27; wr_data = 8'h9C;
    step("R9 conflict");
    peek(26, 27, "R9 alu wins");
    ptr_sel = 0; ptr_op = 2; wr_en = 1; wr_imm = 1; wr_sel = 3; wr_data = 8'h01;
    step("R9 no conflict on illegal");

    // R10 memory window
    mem_en = 1; mem_addr = 16'h001F; step("R10 read 0x1F");
    mem_en = 1; mem_we = 1; mem_addr = 16'h0003; mem_wdata = 8'h5A; step("R10 write");
    peek(3, 0, "R10 readback");

    // R11 outside the window
    mem_en = 1; mem_we = 1; mem_addr = 16'h0020; mem_wdata = 8'hDE; step("R11 0x20");
    mem_en = 1; mem_we = 1; mem_addr = 16'h1020; mem_wdata = 8'hAD; step("R11 alias");
    peek(0, 1, "R11 unchanged");

    // R12 priority among write sources
    mem_en = 1; mem_we = 1; mem_addr = 16'h0008; mem_wdata = 8'h44;
    wr_en = 1; wr_sel = 8; wr_data = 8'h88; step("R12 alu over mem");
    peek(8, 9, "R12 alu kept");
    mem_en = 1; mem_we = 1; mem_addr = 16'h001E; mem_wdata = 8'h66;
    ptr_sel = 2; ptr_op = 3; step("R12 mem over pointer");
    peek(30, 31, "R12 mem kept");

    // Final sweep of the whole file
    for (int i = 0; i < 16; i++) peek(i, 31 - i, "R3 final sweep");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule